// File: doc/BRIEF.md
# UART Receive Buffer with Ageing Timeout

This block sits between a UART deserializer and the host bus logic. Each received character is 16 bits wide and arrives with a one-cycle write strobe. The block holds up to 32 such characters in arrival order and hands them out one per host read strobe. A ready flag tells the host that enough characters have gathered to make a burst read worthwhile. The threshold is a 6-bit trigger level.

A few characters can sit below the trigger level when the line goes quiet. An ageing timer catches that case. It counts baud ticks while the buffer holds at least one character but fewer than the trigger level. Any push or read restarts it. If it reaches 64 ticks (eight 8-bit characters), it raises a sticky ageing flag, which the host clears with a write-one-to-clear strobe. Either flag can raise the interrupt line, each under its own enable bit.

The host read returns a registered word one cycle after the strobe. Bit 15 of that word marks valid data. A read of an empty buffer returns bit 14 set and bit 15 clear.

Top module: `rx_age_fifo`

## Requirements
- R1: Characters are read back in the order they were pushed, and the buffer holds up to 32 of them.
- R2: A push that leaves the fill level at or above `trig_lvl_i` sets `rdy_o`. A push that leaves it below does not set `rdy_o`.
- R3: A valid read clears `rdy_o` only when the remaining fill level is below `trig_lvl_i`. Otherwise `rdy_o` stays set.
- R4: Any push sets `data_rdy_o` and clears `rx_empty_o`. These two change back only when a read leaves the buffer empty.
- R5: The ageing timer advances on `baud_tick_i` only while the fill level is non-zero and below `trig_lvl_i`. Every push and every read restarts it from zero.
- R6: On the 64th counted tick without a restart, `age_o` is set. It stays set until `age_clr_i` is pulsed.
- R7: `irq_o` is high when `rdy_o` and `rdy_ie_i` are both high, or when `age_o` and `age_en_i` are both high. It is low otherwise.
- R8: On the cycle after a read strobe, `rd_data_o` holds the oldest character with bit 15 forced to 1 (other bits pass through). A read of an empty buffer gives 16'h4000 (bit 14 set, bit 15 clear).
- R9: `can_accept_o` is high only when `rx_en_i` is high, `rdy_ie_i` is high and the buffer is not full. `full_o` is high when 32 characters are held.
- R10: A push into a full buffer with no read discards the oldest character and stores the new one. The fill level stays at 32.
- R11: After reset the buffer is empty: `rx_empty_o` is 1, and `rdy_o`, `data_rdy_o`, `age_o`, `full_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Character push strobe from the deserializer |
| wr_data_i | input | 16 | Received character |
| rd_en_i | input | 1 | Host read strobe |
| rd_data_o | output | 16 | Registered read word: bit 15 valid, bit 14 error on empty read |
| trig_lvl_i | input | 6 | Trigger level for the ready flag |
| age_en_i | input | 1 | Lets the ageing flag drive the interrupt |
| rdy_ie_i | input | 1 | Lets the ready flag drive the interrupt; also gates acceptance |
| rx_en_i | input | 1 | Receive enable, gates acceptance |
| baud_tick_i | input | 1 | One-cycle baud time base for the ageing timer |
| age_clr_i | input | 1 | Write-one-to-clear strobe for the ageing flag |
| rdy_o | output | 1 | Trigger-level ready flag |
| data_rdy_o | output | 1 | At least one character held |
| rx_empty_o | output | 1 | No character held |
| age_o | output | 1 | Sticky ageing timeout flag |
| full_o | output | 1 | Buffer holds 32 characters |
| can_accept_o | output | 1 | Receiver may deliver another character |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench runs four fill patterns: a short run up to the trigger level, a drain down through the level, a run past capacity, and a gap in which the timer must expire. The short run and the drain test the asymmetric set and clear rule of the ready flag. Each drain read is also scored for order. The capacity run shows that the oldest characters are dropped and the newest 32 kept. For the timer, the bench compares an uninterrupted count of 64 ticks with one broken by a push and a read. It also shows that the timer stays silent when the buffer is empty or at the trigger level.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned CHAR_W    = 16;
  localparam int unsigned VALID_BIT = 15;
  localparam int unsigned ERR_BIT   = 14;

  // timer window: something held, but less than the trigger level
  function automatic logic in_age_window(input int unsigned fill, input int unsigned lvl);
    return (fill != 0) && (fill < lvl);
  endfunction

  function automatic logic at_level(input int unsigned fill, input int unsigned lvl);
    return fill >= lvl;
  endfunction

  // read word: head with valid flag, or the error word when empty
  function automatic logic [CHAR_W-1:0] read_word(input logic [CHAR_W-1:0] head, input logic ok);
    logic [CHAR_W-1:0] w;
    if (ok) begin
      w = head;
      w[VALID_BIT] = 1'b1;
    end else begin
      w = '0;
      w[ERR_BIT] = 1'b1;
    end
    return w;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             full,
  output logic             pop_ok,
  output logic             drop
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign pop_ok    = pop && (count != '0);
  assign drop      = push && full && !pop_ok;
  assign count_nxt = count + CNT_W'(push) - CNT_W'(pop_ok) - CNT_W'(drop);
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)            wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok || drop)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count_nxt;
    end
  end
endmodule

// File: rtl/rxf_age.sv
module rxf_age #(
  parameter int AGE_TICKS = 64,
  localparam int TW = $clog2(AGE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic armed,
  input  logic tick,
  output logic expire
);
  logic [TW-1:0] ticks;
  logic          fired;

  assign expire = armed && !restart && tick && !fired && (ticks == TW'(AGE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks <= '0;
      fired <= 1'b0;
    end else if (restart || !armed) begin
      ticks <= '0;
      fired <= 1'b0;
    end else if (tick && !fired) begin
      if (expire) begin
        ticks <= '0;
        fired <= 1'b1;
      end else begin
        ticks <= ticks + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_age_fifo.sv
module rx_age_fifo #(
  parameter int DEPTH     = 32,
  parameter int TL_W      = 6,
  parameter int AGE_TICKS = 64,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [rxf_pkg::CHAR_W-1:0] wr_data_i,
  input  logic                      rd_en_i,
  output logic [rxf_pkg::CHAR_W-1:0] rd_data_o,
  input  logic [TL_W-1:0]           trig_lvl_i,
  input  logic                      age_en_i,
  input  logic                      rdy_ie_i,
  input  logic                      rx_en_i,
  input  logic                      baud_tick_i,
  input  logic                      age_clr_i,
  output logic                      rdy_o,
  output logic                      data_rdy_o,
  output logic                      rx_empty_o,
  output logic                      age_o,
  output logic                      full_o,
  output logic                      can_accept_o,
  output logic                      irq_o
);
  import rxf_pkg::*;

  logic [CHAR_W-1:0] head;
  logic [CNT_W-1:0]  count, count_nxt;
  logic              pop_ok, drop, armed, restart, expire;
  logic              rdy_q, drdy_q, age_q;
  logic [CHAR_W-1:0] rd_q;

  rxf_store #(.DEPTH(DEPTH), .W(CHAR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(wr_en_i), .pop(rd_en_i), .wdata(wr_data_i),
    .head(head), .count(count), .count_nxt(count_nxt), .full(full_o),
    .pop_ok(pop_ok), .drop(drop)
  );

  assign armed   = in_age_window(int'(count), int'(trig_lvl_i));
  assign restart = wr_en_i || rd_en_i;

  rxf_age #(.AGE_TICKS(AGE_TICKS)) u_age (
    .clk(clk), .rst_n(rst_n), .restart(restart), .armed(armed),
    .tick(baud_tick_i), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      drdy_q <= 1'b0;
      age_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (wr_en_i && at_level(int'(count_nxt), int'(trig_lvl_i)))
        rdy_q <= 1'b1;
      else if (pop_ok && !at_level(int'(count_nxt), int'(trig_lvl_i)))
        rdy_q <= 1'b0;

      if (wr_en_i)                          drdy_q <= 1'b1;
      else if (pop_ok && count_nxt == '0)   drdy_q <= 1'b0;

      if (expire)         age_q <= 1'b1;
      else if (age_clr_i) age_q <= 1'b0;

      if (rd_en_i) rd_q <= read_word(head, pop_ok);
    end
  end

  assign rd_data_o    = rd_q;
  assign rdy_o        = rdy_q;
  assign data_rdy_o   = drdy_q;
  assign rx_empty_o   = !drdy_q;
  assign age_o        = age_q;
  assign can_accept_o = rx_en_i && rdy_ie_i && !full_o;
  assign irq_o        = (rdy_q && rdy_ie_i) || (age_q && age_en_i);
endmodule

// File: rtl/rxf_checks.sv
module rxf_checks #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6,
  parameter int TL_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [TL_W-1:0]  trig_lvl_i,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] count_nxt,
  input logic             armed,
  input logic             full_o,
  input logic             rdy_o,
  input logic             data_rdy_o,
  input logic             age_o,
  input logic             can_accept_o,
  input logic [15:0]      rd_data_o
);
  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_rdy_on_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && ({{(32-CNT_W){1'b0}}, count_nxt} >= {{(32-TL_W){1'b0}}, trig_lvl_i})) |=> rdy_o);

  p_drdy_tracks_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy_o == (count != '0));

  p_age_needs_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(age_o) |-> $past(armed));

  p_empty_read_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && count == '0) |=> (rd_data_o[14] && !rd_data_o[15]));

  p_accept_not_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    can_accept_o |-> !full_o);

  p_overflow_keeps_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && wr_en_i && !rd_en_i) |=> full_o);
endmodule

bind rx_age_fifo rxf_checks #(.DEPTH(DEPTH), .CNT_W(CNT_W), .TL_W(TL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .trig_lvl_i(trig_lvl_i), .count(count), .count_nxt(count_nxt), .armed(armed),
  .full_o(full_o), .rdy_o(rdy_o), .data_rdy_o(data_rdy_o), .age_o(age_o),
  .can_accept_o(can_accept_o), .rd_data_o(rd_data_o)
);

// File: tb/sim_rx_age_fifo.sv
`timescale 1ns/1ps
module sim_rx_age_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, age_clr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [5:0]  tl = 6'd8;
  logic        age_en = 1'b1, rdy_ie = 1'b1, rx_en = 1'b1;
  logic        rdy, drdy, rx_empty, age, full, can_acc, irq;

  int checks = 0;
  int fails  = 0;
  logic [15:0] q[$];
  logic rd_d = 1'b0;

  always #5 clk = ~clk;

  rx_age_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .trig_lvl_i(tl), .age_en_i(age_en), .rdy_ie_i(rdy_ie),
    .rx_en_i(rx_en), .baud_tick_i(tick), .age_clr_i(age_clr), .rdy_o(rdy),
    .data_rdy_o(drdy), .rx_empty_o(rx_empty), .age_o(age), .full_o(full),
    .can_accept_o(can_acc), .irq_o(irq)
  );

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string tag);
    chk(act == exp, tag, {15'd0, act}, {15'd0, exp});
  endtask

  // driver: push into design and scoreboard; full model drops the oldest
  task automatic push_char(input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    if (q.size() == 32) void'(q.pop_front());
    q.push_back(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_char();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  always @(posedge clk) rd_d <= rd_en;

  // monitor: compare each read word against the scoreboard (R1, R8)
  initial begin
    forever begin
      @(negedge clk);
      if (rd_d) begin
        logic [15:0] exp;
        if (q.size() == 0) exp = 16'h4000;
        else exp = q.pop_front() | 16'h8000;
        chk(rd_data == exp, "R1/R8 read word", rd_data, exp);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk1(rx_empty, 1'b1, "R11 rx_empty");
    chk1(rdy, 1'b0, "R11 rdy");
    chk1(drdy, 1'b0, "R11 data_rdy");
    chk1(age, 1'b0, "R11 age");
    chk1(full, 1'b0, "R11 full");
    chk1(irq, 1'b0, "R11 irq");
    chk1(can_acc, 1'b1, "R9 can_accept idle");

    read_char();                       // R8 empty read checked by monitor
    @(negedge clk);

    for (int i = 0; i < 7; i++) push_char(16'h0100 + 16'(i));
    chk1(rdy, 1'b0, "R2 below level");
    chk1(drdy, 1'b1, "R4 data_rdy after push");
    chk1(rx_empty, 1'b0, "R4 rx_empty after push");
    push_char(16'h0107);
    chk1(rdy, 1'b1, "R2 at level");
    chk1(irq, 1'b1, "R7 irq from rdy");

    tl = 6'd6;
    read_char();
    chk1(rdy, 1'b1, "R3 7 left stays");
    read_char();
    chk1(rdy, 1'b1, "R3 6 left stays");
    read_char();
    chk1(rdy, 1'b0, "R3 5 left clears");
    chk1(irq, 1'b0, "R7 irq drops with rdy");

    // R6 ageing expiry after 64 ticks
    ticks(63);
    chk1(age, 1'b0, "R6 63 ticks");
    ticks(1);
    chk1(age, 1'b1, "R6 64 ticks");
    chk1(irq, 1'b1, "R7 irq from age");
    age_en = 1'b0;
    @(negedge clk);
    chk1(irq, 1'b0, "R7 age masked");
    age_en = 1'b1;
    ticks(80);
    chk1(age, 1'b1, "R6 sticky");
    @(negedge clk); age_clr = 1'b1;
    @(negedge clk); age_clr = 1'b0;
    chk1(age, 1'b0, "R6 cleared");

    // R5 restarts by read and push
    read_char();
    ticks(40);
    push_char(16'h4123);
    ticks(63);
    chk1(age, 1'b0, "R5 restart on push");
    ticks(1);
    chk1(age, 1'b1, "R5 expiry after restart");
    @(negedge clk); age_clr = 1'b1;
    @(negedge clk); age_clr = 1'b0;

    // R5 stopped at or above level
    tl = 6'd2;
    ticks(100);
    chk1(age, 1'b0, "R5 no ageing at level");

    // drain (R4)
    while (q.size() > 1) read_char();
    chk1(drdy, 1'b1, "R4 one left");
    read_char();
    chk1(drdy, 1'b0, "R4 data_rdy empty");
    chk1(rx_empty, 1'b1, "R4 rx_empty empty");
    tl = 6'd8;
    ticks(100);
    chk1(age, 1'b0, "R5 no ageing when empty");

    // R10 overflow
    for (int i = 0; i < 32; i++) push_char(16'h0200 + 16'(i));
    chk1(full, 1'b1, "R9 full at 32");
    chk1(can_acc, 1'b0, "R9 no accept when full");
    for (int i = 0; i < 3; i++) push_char(16'h0300 + 16'(i));
    chk1(full, 1'b1, "R10 full after overflow");
    read_char();
    chk1(full, 1'b0, "R10 31 left after one read");
    chk1(can_acc, 1'b1, "R9 accept after read");
    rx_en = 1'b0;
    @(negedge clk);
    chk1(can_acc, 1'b0, "R9 rx disabled");
    rx_en = 1'b1; rdy_ie = 1'b0;
    @(negedge clk);
    chk1(can_acc, 1'b0, "R9 rdy_ie off");
    rdy_ie = 1'b1;
    while (q.size() > 0) read_char();
    read_char();
    @(negedge clk);
    finish_run();
  end
endmodule